// File: doc/BRIEF.md
# PHY Bring-up Sequencer

This block brings an external Ethernet PHY from an unknown state to a configured, negotiated link. It drives a request/response port of a separate management-frame engine, which serializes the actual register accesses. After a start pulse it searches the management address space for the first device that returns a believable identifier pair. It then soft-resets that device and polls until the reset completes. Next it builds an advertisement word from the device's own capability bits, enables and restarts autonegotiation, and polls for completion. A remote fault seen during polling restarts negotiation. Finally it reads the vendor detection register and latches the resolved link speed and duplex.

Waits between polls are measured in ticks of a millisecond strobe, so the block needs no knowledge of the clock frequency. The sequence always ends with a one-cycle done pulse, whatever the outcome. The result flags stay readable until the next start.

Top module: `phy_bringup_seq`

## Requirements
- R1: After start, identifier reads walk addresses upward from 0. Each address is read at register 2 and then at register 3, and the next address follows only after both reads.
- R2: An address is accepted only when both identifier words differ from 0x0000, 0xFFFF and 0x8000. The scan stops at the first accepted address, which is reported on `phy_addr` with `found` = 1.
- R3: If no address up to 31 is accepted, the sequence ends after exactly 64 identifier reads with `found` = 0 and no further access.
- R4: After discovery, register 0 is written with 0x8000 (reset bit 15 alone). Register 0 is then read until bit 15 is clear, at most RST_TRIES times, with exactly POLL_MS tick pulses between a failing read and the next read.
- R5: If all RST_TRIES reset reads show bit 15 set, `rst_tmo` = 1 and the sequence ends with no further access.
- R6: After reset, register 1 is read once. Register 4 is then written with selector 0x0001 plus bit 9 from status bit 15, bit 8 from bit 14, bit 7 from bit 13, bit 6 from bit 12 and bit 5 from bit 11. All other bits are zero.
- R7: Register 0 is then written with 0x3300 (speed bit 13, enable bit 12, restart bit 9, duplex bit 8). Register 1 is polled up to AN_TRIES times for bit 5, with POLL_MS ticks between polls.
- R8: A poll with bit 5 clear and remote-fault bit 4 set sets `rem_fault`. If polls remain, it is followed, after the wait, by another 0x3300 write to register 0. A poll with bit 5 set ends polling even when bit 4 is also set, and does not set `rem_fault`.
- R9: If AN_TRIES polls all lack bit 5, `an_tmo` = 1 and the sequence still continues to R10.
- R10: Register 18 is read last. Its bit 7 is latched into `spd_100` and its bit 6 into `full_dplx`.
- R11: `done` is high for exactly one cycle after the final response, with no request pending. The result outputs hold until the next start, which clears them. After reset, `done`, `found` and `req_valid` are 0.
- R12: A start pulse while a sequence is running has no effect on the access sequence or the results.
- R13: A request keeps `req_valid` and its fields unchanged until `resp_valid`. Every access after discovery uses the accepted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up sequence (used only when idle) |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| req_valid | output | 1 | Management access requested |
| req_wr | output | 1 | 1 = write, 0 = read |
| req_phy | output | 5 | Device address of the access |
| req_reg | output | 5 | Register number of the access |
| req_wdata | output | 16 | Write data |
| resp_valid | input | 1 | Access finished (one cycle) |
| resp_data | input | 16 | Read data, valid with resp_valid |
| done | output | 1 | Sequence finished pulse |
| found | output | 1 | A device was accepted |
| phy_addr | output | 5 | Accepted device address |
| spd_100 | output | 1 | Resolved 100 Mb/s speed |
| full_dplx | output | 1 | Resolved full duplex |
| rst_tmo | output | 1 | Device reset never completed |
| an_tmo | output | 1 | Negotiation never completed |
| rem_fault | output | 1 | Remote fault seen while negotiating |

## Verification
A corrupted scan address or poll count shows up at the next management request. The wrong register number, address or write word is visible on the request port the first cycle that request is raised. Pacing errors appear as a tick count between a failing poll's response and the next request that differs from POLL_MS. A lost or extra restart changes the number of 0x3300 writes seen before done. A state machine that skips or repeats a stage changes the total access count, or the flags latched at the done pulse, within the same sequence.

// File: rtl/physeq_pkg.sv
package physeq_pkg;
  localparam int DW     = 16;
  localparam int REG_W  = 5;

  localparam logic [REG_W-1:0] R_CTRL = 5'd0;
  localparam logic [REG_W-1:0] R_STAT = 5'd1;
  localparam logic [REG_W-1:0] R_IDH  = 5'd2;
  localparam logic [REG_W-1:0] R_IDL  = 5'd3;
  localparam logic [REG_W-1:0] R_ADV  = 5'd4;
  localparam logic [REG_W-1:0] R_VEND = 5'd18;

  localparam int CTRL_RST_B  = 15;
  localparam int STAT_DONE_B = 5;
  localparam int STAT_FLT_B  = 4;
  localparam int VEND_SPD_B  = 7;
  localparam int VEND_DPX_B  = 6;

  localparam int NCAP    = 5;
  localparam int CAP_LSB = 11;
  localparam int ADV_LSB = 5;

  localparam logic [DW-1:0]      CTRL_RST_WORD = 16'h8000;
  localparam logic [DW-1:0]      CTRL_AN_WORD  = 16'h3300;
  localparam logic [ADV_LSB-1:0] ADV_SEL       = 5'b00001;

  typedef enum logic [3:0] {
    S_IDLE, S_ID1, S_ID2, S_RSTW, S_RSTR, S_RSTWAIT, S_CAPR,
    S_ADVW, S_ANW, S_ANR, S_ANWAIT, S_VENDR, S_FIN
  } seq_st_t;
endpackage

// File: rtl/physeq_idchk.sv
module physeq_idchk #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] id_a,
  input  logic [DW-1:0] id_b,
  output logic          ok
);
  localparam logic [DW-1:0] MSB_ONLY = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] words [2];
  logic [1:0]    plausible;

  assign words[0] = id_a;
  assign words[1] = id_b;

  for (genvar i = 0; i < 2; i++) begin : g_word
    assign plausible[i] = (words[i] != '0) && (words[i] != '1) && (words[i] != MSB_ONLY);
  end

  assign ok = &plausible;
endmodule

// File: rtl/physeq_advmap.sv
module physeq_advmap
  import physeq_pkg::*;
(
  input  logic [NCAP-1:0] caps,
  output logic [DW-1:0]   adv
);
  for (genvar i = 0; i < NCAP; i++) begin : g_cap
    assign adv[ADV_LSB+i] = caps[i];
  end
  assign adv[ADV_LSB-1:0]     = ADV_SEL;
  assign adv[DW-1:ADV_LSB+NCAP] = '0;
endmodule

// File: rtl/physeq_pace.sv
module physeq_pace #(
  parameter int TICKS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expire = run && tick && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (expire) cnt_d = '0;
    else if (tick)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4 / R7: the wait counter never passes the programmed tick count
  a_r4_pace_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(TICKS));
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import physeq_pkg::*;
#(
  parameter int POLL_MS   = 500,
  parameter int RST_TRIES = 6,
  parameter int AN_TRIES  = 20,
  parameter int ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick_ms,
  output logic              req_valid,
  output logic              req_wr,
  output logic [ADDR_W-1:0] req_phy,
  output logic [REG_W-1:0]  req_reg,
  output logic [DW-1:0]     req_wdata,
  input  logic              resp_valid,
  input  logic [DW-1:0]     resp_data,
  output logic              done,
  output logic              found,
  output logic [ADDR_W-1:0] phy_addr,
  output logic              spd_100,
  output logic              full_dplx,
  output logic              rst_tmo,
  output logic              an_tmo,
  output logic              rem_fault
);
  localparam int MAXT = (RST_TRIES > AN_TRIES) ? RST_TRIES : AN_TRIES;
  localparam int CNT_W = $clog2(MAXT + 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;
  localparam logic [CNT_W-1:0]  RST_LAST  = CNT_W'(RST_TRIES - 1);
  localparam logic [CNT_W-1:0]  AN_LAST   = CNT_W'(AN_TRIES - 1);

  seq_st_t           st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DW-1:0]     id1_q, id1_d;
  logic [NCAP-1:0]   caps_q, caps_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              again_q, again_d;
  logic              found_q, found_d, rtmo_q, rtmo_d, atmo_q, atmo_d;
  logic              flt_q, flt_d, spd_q, spd_d, dpx_q, dpx_d;

  logic          id_ok, pace_run, pace_done;
  logic [DW-1:0] adv_word;

  physeq_idchk #(.DW(DW)) u_idchk (.id_a(id1_q), .id_b(resp_data), .ok(id_ok));
  physeq_advmap u_adv (.caps(caps_q), .adv(adv_word));

  assign pace_run = (st_q == S_RSTWAIT) || (st_q == S_ANWAIT);
  physeq_pace #(.TICKS(POLL_MS)) u_pace (
    .clk(clk), .rst_n(rst_n), .run(pace_run), .tick(tick_ms), .expire(pace_done));

  // next-state logic
  always_comb begin
    st_d = st_q;  addr_d = addr_q;  id1_d = id1_q;  caps_d = caps_q;
    cnt_d = cnt_q;  again_d = again_q;  found_d = found_q;  rtmo_d = rtmo_q;
    atmo_d = atmo_q;  flt_d = flt_q;  spd_d = spd_q;  dpx_d = dpx_q;
    case (st_q)
      S_IDLE: if (start) begin
        st_d = S_ID1;  addr_d = '0;  found_d = 1'b0;  rtmo_d = 1'b0;
        atmo_d = 1'b0;  flt_d = 1'b0;  spd_d = 1'b0;  dpx_d = 1'b0;
      end
      S_ID1: if (resp_valid) begin
        id1_d = resp_data;  st_d = S_ID2;
      end
      S_ID2: if (resp_valid) begin
        if (id_ok) begin
          found_d = 1'b1;  st_d = S_RSTW;
        end else if (addr_q == ADDR_LAST) begin
          st_d = S_FIN;
        end else begin
          addr_d = addr_q + 1'b1;  st_d = S_ID1;
        end
      end
      S_RSTW: if (resp_valid) begin
        cnt_d = '0;  st_d = S_RSTR;
      end
      S_RSTR: if (resp_valid) begin
        if (!resp_data[CTRL_RST_B]) st_d = S_CAPR;
        else if (cnt_q == RST_LAST) begin
          rtmo_d = 1'b1;  st_d = S_FIN;
        end else begin
          cnt_d = cnt_q + 1'b1;  st_d = S_RSTWAIT;
        end
      end
      S_RSTWAIT: if (pace_done) st_d = S_RSTR;
      S_CAPR: if (resp_valid) begin
        caps_d = resp_data[CAP_LSB +: NCAP];  st_d = S_ADVW;
      end
      S_ADVW: if (resp_valid) begin
        cnt_d = '0;  st_d = S_ANW;
      end
      S_ANW: if (resp_valid) st_d = S_ANR;
      S_ANR: if (resp_valid) begin
        if (resp_data[STAT_DONE_B]) st_d = S_VENDR;
        else begin
          if (resp_data[STAT_FLT_B]) flt_d = 1'b1;
          if (cnt_q == AN_LAST) begin
            atmo_d = 1'b1;  st_d = S_VENDR;
          end else begin
            cnt_d = cnt_q + 1'b1;  again_d = resp_data[STAT_FLT_B];  st_d = S_ANWAIT;
          end
        end
      end
      S_ANWAIT: if (pace_done) st_d = again_q ? S_ANW : S_ANR;
      S_VENDR: if (resp_valid) begin
        spd_d = resp_data[VEND_SPD_B];  dpx_d = resp_data[VEND_DPX_B];  st_d = S_FIN;
      end
      S_FIN: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // request decode
  always_comb begin
    req_valid = 1'b1;  req_wr = 1'b0;  req_reg = R_CTRL;  req_wdata = '0;
    case (st_q)
      S_ID1:   req_reg = R_IDH;
      S_ID2:   req_reg = R_IDL;
      S_RSTW:  begin req_wr = 1'b1;  req_wdata = CTRL_RST_WORD; end
      S_RSTR:  req_reg = R_CTRL;
      S_CAPR:  req_reg = R_STAT;
      S_ADVW:  begin req_wr = 1'b1;  req_reg = R_ADV;  req_wdata = adv_word; end
      S_ANW:   begin req_wr = 1'b1;  req_wdata = CTRL_AN_WORD; end
      S_ANR:   req_reg = R_STAT;
      S_VENDR: req_reg = R_VEND;
      default: req_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  addr_q <= '0;  id1_q <= '0;  caps_q <= '0;  cnt_q <= '0;
      again_q <= 1'b0;  found_q <= 1'b0;  rtmo_q <= 1'b0;  atmo_q <= 1'b0;
      flt_q <= 1'b0;  spd_q <= 1'b0;  dpx_q <= 1'b0;
    end else begin
      st_q <= st_d;  addr_q <= addr_d;  id1_q <= id1_d;  caps_q <= caps_d;  cnt_q <= cnt_d;
      again_q <= again_d;  found_q <= found_d;  rtmo_q <= rtmo_d;  atmo_q <= atmo_d;
      flt_q <= flt_d;  spd_q <= spd_d;  dpx_q <= dpx_d;
    end
  end

  assign req_phy   = addr_q;
  assign done      = (st_q == S_FIN);
  assign found     = found_q;
  assign phy_addr  = addr_q;
  assign spd_100   = spd_q;
  assign full_dplx = dpx_q;
  assign rst_tmo   = rtmo_q;
  assign an_tmo    = atmo_q;
  assign rem_fault = flt_q;

  // R1: moving from an ID2 read to an ID1 read advances the address by one
  a_r1_scan_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_reg == R_IDH && $past(req_valid) && $past(req_reg) == R_IDL)
      |-> req_phy == ADDR_W'($past(req_phy) + 1'b1));
  // R13: a pending request holds until answered
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !resp_valid) |=> (req_valid && $stable(req_reg) && $stable(req_wr) && $stable(req_phy)));
  // R13: the accepted address does not move while the device is being configured
  a_r13_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (found && $past(found)) |-> $stable(req_phy));
  // R4 / R7: only the two defined control words are ever written
  a_r4_ctrl_words: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_wr && req_reg == R_CTRL) |-> (req_wdata == CTRL_RST_WORD || req_wdata == CTRL_AN_WORD));
  // R6: the advertisement always carries the selector
  a_r6_selector: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_wr && req_reg == R_ADV) |-> req_wdata[ADV_LSB-1:0] == ADV_SEL);
  // R11: done is a single-cycle pulse with no request outstanding
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);
endmodule

// File: tb/phy_bringup_seq_tb.sv
module phy_bringup_seq_tb;
  localparam int PACE = 20;

  logic        clk, rst_n, start, tick_ms;
  logic        req_valid, req_wr;
  logic [4:0]  req_phy, req_reg, phy_addr;
  logic [15:0] req_wdata, resp_data;
  logic        resp_valid, done, found, spd_100, full_dplx, rst_tmo, an_tmo, rem_fault;

  phy_bringup_seq #(.POLL_MS(PACE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tick_ms(tick_ms),
    .req_valid(req_valid), .req_wr(req_wr), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_data(resp_data),
    .done(done), .found(found), .phy_addr(phy_addr), .spd_100(spd_100),
    .full_dplx(full_dplx), .rst_tmo(rst_tmo), .an_tmo(an_tmo), .rem_fault(rem_fault));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  // device model state
  logic [15:0] id1_m [32];
  logic [15:0] id2_m [32];
  int          rst_left, an_need;
  logic [31:0] flt_mask;
  logic [15:0] caps, r18;

  // observation counters
  int n_rstw, n_anw, n_oddw, n_advw, n_ctlr, n_str, n_r18, n_tot;
  int scan_idx, scan_bad, bad_phy, gap_bad, hold_bad, exp_phy, tick_cnt, lat;
  logic [15:0] adv_seen;
  bit in_txn, wait_flag;
  logic [4:0] h_phy, h_reg;
  logic h_wr;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic bit plaus(input logic [15:0] w);
    return (w != 16'h0000) && (w != 16'hFFFF) && (w != 16'h8000);
  endfunction

  function automatic int first_ok();
    for (int a = 0; a < 32; a++)
      if (plaus(id1_m[a]) && plaus(id2_m[a])) return a;
    return -1;
  endfunction

  function automatic logic [15:0] adv_of(input logic [15:0] c);
    logic [15:0] w;
    w = 16'h0001;
    w[9] = c[15]; w[8] = c[14]; w[7] = c[13]; w[6] = c[12]; w[5] = c[11];
    return w;
  endfunction

  // management engine model and tick source
  task automatic note_request();
    n_tot++;
    if (wait_flag) begin
      if (tick_cnt != PACE) gap_bad++;
      wait_flag = 1'b0;
    end
    if (!req_wr && (req_reg == 5'd2 || req_reg == 5'd3)) begin
      if (int'(req_phy) != scan_idx / 2 || req_reg != ((scan_idx % 2 == 0) ? 5'd2 : 5'd3)) scan_bad++;
      scan_idx++;
    end else if (int'(req_phy) != exp_phy) bad_phy++;
    h_phy = req_phy; h_reg = req_reg; h_wr = req_wr;
  endtask

  task automatic serve();
    int p;
    resp_data = 16'h0000;
    if (req_wr) begin
      if (req_reg == 5'd0) begin
        if (req_wdata == 16'h8000) n_rstw++;
        else if (req_wdata == 16'h3300) n_anw++;
        else n_oddw++;
      end else if (req_reg == 5'd4) begin
        n_advw++; adv_seen = req_wdata;
      end else n_oddw++;
    end else begin
      case (req_reg)
        5'd2: resp_data = id1_m[req_phy];
        5'd3: resp_data = id2_m[req_phy];
        5'd0: begin
          n_ctlr++;
          if (rst_left > 0) begin
            rst_left--; resp_data = 16'h8000; wait_flag = (n_ctlr < 6);
          end
        end
        5'd1: begin
          n_str++;
          if (n_str == 1) resp_data = caps;
          else begin
            p = n_str - 1;
            resp_data = (caps & 16'hF800) | ((p >= an_need) ? 16'h0020 : 16'h0000)
                        | (flt_mask[p] ? 16'h0010 : 16'h0000);
            wait_flag = (p < an_need) && (p < 20);
          end
        end
        5'd18: begin n_r18++; resp_data = r18; end
        default: n_oddw++;
      endcase
    end
  endtask

  initial begin
    resp_valid = 1'b0; resp_data = 16'h0; tick_ms = 1'b0; in_txn = 1'b0;
    wait_flag = 1'b0; tick_cnt = 0; lat = 0;
    forever begin
      @(negedge clk);
      if (resp_valid) resp_valid = 1'b0;
      else if (req_valid) begin
        if (!in_txn) begin
          in_txn = 1'b1; lat = int'($urandom % 3); note_request();
        end else if (req_phy != h_phy || req_reg != h_reg || req_wr != h_wr) hold_bad++;
        if (lat == 0) begin
          serve(); in_txn = 1'b0; resp_valid = 1'b1;
        end else lat--;
      end else if (in_txn) begin
        hold_bad++; in_txn = 1'b0;
      end
      tick_ms = ($urandom % 3) != 0;
      if (resp_valid) tick_cnt = 0;
      else if (tick_ms) tick_cnt++;
    end
  end

  task automatic run_case(input string name, input bit glitch);
    int ea, rr, np, rs, tot;
    bit rt, at, fl;
    logic s_found, s_spd;
    ea = first_ok();
    rt = (rst_left >= 6);
    rr = rt ? 6 : rst_left + 1;
    np = (an_need <= 20) ? an_need : 20;
    at = (an_need > 20);
    rs = 0; fl = 1'b0;
    for (int p = 1; p <= np; p++)
      if (p < an_need && flt_mask[p]) begin
        fl = 1'b1;
        if (p < 20) rs++;
      end
    if (ea < 0) tot = 64;
    else if (rt) tot = 2 * (ea + 1) + 1 + 6;
    else tot = 2 * (ea + 1) + 1 + rr + 2 + (1 + rs) + np + 1;

    n_rstw = 0; n_anw = 0; n_oddw = 0; n_advw = 0; n_ctlr = 0; n_str = 0; n_r18 = 0;
    n_tot = 0; scan_idx = 0; scan_bad = 0; bad_phy = 0; gap_bad = 0; hold_bad = 0;
    adv_seen = 16'h0; exp_phy = ea;

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (glitch) begin
      repeat (40) @(negedge clk);
      start = 1'b1;  // R12: must be ignored mid-sequence
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);

    $display("case %s: addr %0d", name, ea);
    chk("R1", "scan order errors", scan_bad, 0);
    chk("R2", "found", int'(found), (ea >= 0) ? 1 : 0);
    if (ea >= 0) chk("R2", "phy_addr", int'(phy_addr), ea);
    chk("R12", "total accesses", n_tot, tot);
    chk("R13", "foreign address accesses", bad_phy, 0);
    chk("R13", "request hold errors", hold_bad, 0);
    chk("R5", "rst_tmo", int'(rst_tmo), (ea >= 0 && rt) ? 1 : 0);
    if (ea < 0) begin
      chk("R3", "non-scan accesses", n_tot - scan_idx, 0);
      chk("R11", "flags cleared by start", int'({spd_100, full_dplx, an_tmo, rem_fault}), 0);
    end else begin
      chk("R4", "reset writes", n_rstw, 1);
      chk("R4", "reset reads", n_ctlr, rr);
      chk("R4", "poll spacing errors", gap_bad, 0);
      if (!rt) begin
        chk("R6", "advertisement", int'(adv_seen), int'(adv_of(caps)));
        chk("R7", "restart writes", n_anw, 1 + rs);
        chk("R7", "status reads", n_str, 1 + np);
        chk("R8", "rem_fault", int'(rem_fault), int'(fl));
        chk("R9", "an_tmo", int'(an_tmo), int'(at));
        chk("R10", "spd_100", int'(spd_100), int'(r18[7]));
        chk("R10", "full_dplx", int'(full_dplx), int'(r18[6]));
      end else begin
        chk("R5", "status reads after timeout", n_str, 0);
        chk("R11", "speed cleared", int'(spd_100), 0);
      end
    end
    chk("R13", "odd writes", n_oddw, 0);
    s_found = found; s_spd = spd_100;
    @(negedge clk);
    chk("R11", "done width", int'(done), 0);
    repeat (5) @(negedge clk);
    chk("R11", "found held", int'(found), int'(s_found));
    chk("R11", "speed held", int'(spd_100), int'(s_spd));
  endtask

  function automatic logic [15:0] rnd_good();
    logic [15:0] v;
    v = 16'($urandom % 16'hFFFE) + 16'd1;
    if (v == 16'h8000) v = 16'h8001;
    return v;
  endfunction

  function automatic logic [15:0] rnd_bad();
    case ($urandom % 3)
      0: return 16'h0000;
      1: return 16'hFFFF;
      default: return 16'h8000;
    endcase
  endfunction

  task automatic all_bad();
    for (int a = 0; a < 32; a++) begin
      case (a % 4)
        0: begin id1_m[a] = rnd_bad(); id2_m[a] = rnd_good(); end
        1: begin id1_m[a] = rnd_good(); id2_m[a] = rnd_bad(); end
        2: begin id1_m[a] = 16'h8000; id2_m[a] = 16'h8000; end
        default: begin id1_m[a] = rnd_bad(); id2_m[a] = rnd_bad(); end
      endcase
    end
  endtask

  initial begin
    void'($urandom(32'h1D5EED));
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", "reset done", int'(done), 0);
    chk("R11", "reset found", int'(found), 0);
    chk("R11", "reset req_valid", int'(req_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // device at address 0, immediate reset and negotiation
    all_bad(); id1_m[0] = 16'h0022; id2_m[0] = 16'h1611;
    rst_left = 0; an_need = 1; flt_mask = 0; caps = 16'hF800; r18 = 16'h00C0;
    run_case("addr0", 1'b0);

    // device at the last address, reset clears on the final try, two faults
    all_bad(); id1_m[31] = 16'h0282; id2_m[31] = 16'h1C51;
    rst_left = 5; an_need = 4; flt_mask = 32'h0000000A; caps = 16'h5000; r18 = 16'h0080;
    run_case("addr31_glitch", 1'b1);

    // nothing acceptable anywhere (R3), flags cleared by start (R11)
    all_bad(); rst_left = 0; an_need = 1; flt_mask = 0; caps = 0; r18 = 0;
    run_case("none", 1'b0);

    // reset never completes (R5)
    all_bad(); id1_m[7] = 16'h1234; id2_m[7] = 16'h0001; rst_left = 6;
    an_need = 1; flt_mask = 0; caps = 16'hFFFF; r18 = 16'hFFFF;
    run_case("rst_timeout", 1'b0);

    // negotiation never completes, faults incl. last poll (R9, R8)
    all_bad(); id1_m[2] = 16'h7FFF; id2_m[2] = 16'hFFFE; rst_left = 1;
    an_need = 30; flt_mask = 32'h00100022; caps = 16'h2800; r18 = 16'h0040;
    run_case("an_timeout", 1'b0);

    // completion and fault in the same poll: completion wins (R8)
    all_bad(); id1_m[4] = 16'h8001; id2_m[4] = 16'h7FFF; rst_left = 0;
    an_need = 2; flt_mask = 32'h00000004; caps = 16'h8800; r18 = 16'h0000;
    run_case("done_with_fault", 1'b0);

    for (int k = 0; k < 8; k++) begin
      for (int a = 0; a < 32; a++) begin
        if ($urandom % 8 == 0) begin id1_m[a] = rnd_good(); id2_m[a] = rnd_good(); end
        else if ($urandom % 2 == 0) begin id1_m[a] = rnd_bad(); id2_m[a] = rnd_good(); end
        else begin id1_m[a] = rnd_good(); id2_m[a] = rnd_bad(); end
      end
      if ($urandom % 5 == 0) all_bad();
      rst_left = int'($urandom % 7);
      an_need = 1 + int'($urandom % 22);
      flt_mask = $urandom;
      caps = 16'($urandom);
      r18 = 16'($urandom);
      run_case($sformatf("rand%0d", k), ($urandom % 2) == 1);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule